// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is a single-channel host for a PS/2 keyboard or mouse link. It drives the two open-drain lines through pull-low enables and reads them back through two-flop synchronizers. A small register file gives software three registers: control, status and a byte buffer. One serial engine serves both directions. In receive it shifts in frames clocked by the device. In transmit it holds the clock low to request the bus, then shifts a host byte out under device clocking and checks the device acknowledge.

Frames are a 0 start bit, eight data bits least significant first, an odd parity bit and a 1 stop bit. A good received byte raises a ready flag, which a read of the buffer clears. A bad frame raises a sticky error. Transmit faults raise sticky flags that software clears by writing ones. When a transmit finishes, whether it succeeds or fails, the direction bit falls back to receive without software action. A single level interrupt reports a ready byte or either transmit timeout.

Top module: `ps2_host_port`

## Requirements
- R1: After reset the control register (address 0) reads 0, the clock pull-low output is 1, status (address 1) reads 0x04 and irq is 0. While control bit 0 (enable) is 0, the clock is held low, any transfer is aborted and no byte is received.
- R2: With enable set, a valid device frame sets status bit 0 (ready) and irq, and the data register (address 2) returns the received byte.
- R3: Reading the data register clears ready, and irq falls when no timeout flag is set.
- R4: A frame with a wrong parity bit or a 0 stop bit sets sticky status bit 3 and leaves ready at 0. Writing 1 to bit 3 of status clears it.
- R5: Status bit 1 (receive busy) is 1 during a frame. A data write made during a frame is ignored and starts no transmit, even with control bit 1 set.
- R6: A data write while control bit 1 (direction) is 0 is ignored. The clock is not pulled low and status bit 2 (transmit idle) stays 1.
- R7: With control written to 3, a data write pulls the clock low for exactly RTS_CYCLES cycles. The device then reads the start bit 0, the byte least significant first, the odd parity bit and the stop bit 1 on the data line.
- R8: After the device acknowledges by holding data low on the twelfth clock, control reads 1, status bit 2 is 1 and status bit 6 (no acknowledge) is 0.
- R9: If data is high on the twelfth device clock, sticky status bit 6 is set. irq is not raised by it.
- R10: If no falling clock edge arrives within START_TMO cycles after the clock is released, sticky status bit 5 is set, irq rises, both lines are released and control reads 1.
- R11: If the frame does not finish within FRAME_TMO cycles of the first device clock edge, sticky status bit 4 is set, irq rises and control reads 1.
- R12: Status bits 3 to 6 clear only when 1 is written to their own positions. Writing zeros leaves them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 clears ready) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, combinational |
| ps2_clk_in | input | 1 | Sensed level of the PS/2 clock line |
| ps2_dat_in | input | 1 | Sensed level of the PS/2 data line |
| ps2_clk_low | output | 1 | 1 pulls the clock line low |
| ps2_dat_low | output | 1 | 1 pulls the data line low |
| irq | output | 1 | Level interrupt: ready or either transmit timeout |

## Verification
The hardest situation to reach from the ports is a transmit request that lands while a receive frame is already running. The bench makes it happen by switching the port into transmit mode and then starting a device frame in one thread. A second thread checks receive busy part way through the frame and writes the data register at that point. The bench then confirms that the clock was never pulled low and that the received byte still arrives intact. Both timeouts need a device that goes silent at a chosen moment. The bench model either never clocks at all or stops after three pulses, then waits out the programmed limit.

// File: rtl/ps2hp_pkg.sv
package ps2hp_pkg;

    // Register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // Status bit positions
    localparam int ST_RDY    = 0;
    localparam int ST_RXBUSY = 1;
    localparam int ST_TXIDLE = 2;
    localparam int ST_RXERR  = 3;
    localparam int ST_TMO    = 4;
    localparam int ST_STMO   = 5;
    localparam int ST_NACK   = 6;

    // Engine states
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_RX,
        ENG_RTS,
        ENG_TXWAIT,
        ENG_TX
    } eng_state_e;

    // Single-cycle event pulses from engine to register file
    typedef struct packed {
        logic rx_done;
        logic rx_err;
        logic tx_end;
        logic tx_tmo;
        logic tx_st_tmo;
        logic tx_nack;
    } eng_evt_t;

    function automatic logic odd_par(input logic [7:0] d);
        return ~(^d);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ps2hp_sync.sv
module ps2hp_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) ff <= 2'b11;
            else     ff <= {ff[0], d[g]};
        end
        assign q[g] = ff[1];
    end
endmodule

// File: rtl/ps2hp_engine.sv
module ps2hp_engine
    import ps2hp_pkg::*;
#(
    parameter int RTS_CYCLES = 2000,
    parameter int START_TMO  = 10000,
    parameter int FRAME_TMO  = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tx_start,
    input  logic [7:0] tx_byte,
    input  logic       clk_s,
    input  logic       dat_s,
    output eng_evt_t   evt,
    output logic [7:0] rx_byte,
    output logic       rx_busy,
    output logic       tx_idle,
    output logic       clk_low,
    output logic       dat_low
);
    localparam int LIMIT_MAX = max3(RTS_CYCLES, START_TMO, FRAME_TMO);
    localparam int TMR_W     = $clog2(LIMIT_MAX + 1);
    localparam logic [TMR_W-1:0] RTS_LAST   = TMR_W'(RTS_CYCLES - 1);
    localparam logic [TMR_W-1:0] START_LAST = TMR_W'(START_TMO - 1);
    localparam logic [TMR_W-1:0] FRAME_LAST = TMR_W'(FRAME_TMO - 1);

    eng_state_e       state;
    logic             clk_q;
    logic             fall;
    logic [3:0]       cnt;
    logic [TMR_W-1:0] timer;
    logic [10:0]      txsh;
    logic [7:0]       rxsh;
    logic             rxpar;

    assign fall = clk_q & ~clk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            clk_q <= 1'b1;
            cnt   <= '0;
            timer <= '0;
            txsh  <= '1;
            rxsh  <= '0;
            rxpar <= 1'b0;
            evt   <= '0;
        end else begin
            clk_q <= clk_s;
            evt   <= '0;
            if (!en) begin
                state <= ENG_IDLE;
                cnt   <= '0;
                timer <= '0;
                txsh  <= '1;
            end else begin
                case (state)
                    ENG_IDLE: begin
                        if (tx_start) begin
                            txsh  <= {1'b1, odd_par(tx_byte), tx_byte, 1'b0};
                            timer <= '0;
                            state <= ENG_RTS;
                        end else if (fall && !dat_s) begin
                            cnt   <= 4'd1;
                            state <= ENG_RX;
                        end
                    end
                    ENG_RX: begin
                        if (fall) begin
                            cnt <= cnt + 4'd1;
                            if (cnt <= 4'd8) begin
                                rxsh <= {dat_s, rxsh[7:1]};
                            end else if (cnt == 4'd9) begin
                                rxpar <= dat_s;
                            end else begin
                                state <= ENG_IDLE;
                                cnt   <= '0;
                                if (dat_s && (^{rxpar, rxsh})) evt.rx_done <= 1'b1;
                                else                           evt.rx_err  <= 1'b1;
                            end
                        end
                    end
                    ENG_RTS: begin
                        if (timer == RTS_LAST) begin
                            timer <= '0;
                            state <= ENG_TXWAIT;
                        end else begin
                            timer <= timer + TMR_W'(1);
                        end
                    end
                    ENG_TXWAIT: begin
                        if (fall) begin
                            txsh  <= {1'b1, txsh[10:1]};
                            cnt   <= 4'd1;
                            timer <= '0;
                            state <= ENG_TX;
                        end else if (timer == START_LAST) begin
                            evt.tx_st_tmo <= 1'b1;
                            evt.tx_end    <= 1'b1;
                            txsh          <= '1;
                            state         <= ENG_IDLE;
                        end else begin
                            timer <= timer + TMR_W'(1);
                        end
                    end
                    ENG_TX: begin
                        if (timer == FRAME_LAST) begin
                            evt.tx_tmo <= 1'b1;
                            evt.tx_end <= 1'b1;
                            txsh       <= '1;
                            cnt        <= '0;
                            state      <= ENG_IDLE;
                        end else begin
                            timer <= timer + TMR_W'(1);
                            if (fall) begin
                                cnt <= cnt + 4'd1;
                                if (cnt <= 4'd9) begin
                                    txsh <= {1'b1, txsh[10:1]};
                                end else if (cnt == 4'd11) begin
                                    state       <= ENG_IDLE;
                                    cnt         <= '0;
                                    evt.tx_end  <= 1'b1;
                                    evt.tx_nack <= dat_s;
                                end
                            end
                        end
                    end
                    default: state <= ENG_IDLE;
                endcase
            end
        end
    end

    assign rx_byte = rxsh;
    assign rx_busy = (state == ENG_RX);
    assign tx_idle = !(state == ENG_RTS || state == ENG_TXWAIT || state == ENG_TX);
    assign clk_low = !en || (state == ENG_RTS);
    assign dat_low = (state == ENG_TXWAIT || state == ENG_TX) && !txsh[0];

    // R5
    start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> state == ENG_IDLE);

    // R1
    inhibit_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> state == ENG_IDLE);

    // R7
    rts_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_TXWAIT && $past(state) == ENG_RTS) |-> dat_low);

endmodule

// File: rtl/ps2hp_regs.sv
module ps2hp_regs
    import ps2hp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  eng_evt_t   evt,
    input  logic [7:0] rx_byte,
    input  logic       rx_busy,
    input  logic       tx_idle,
    output logic       en,
    output logic       tx_start,
    output logic [7:0] tx_byte,
    output logic       irq
);
    logic       dir_q;
    logic       rdy;
    logic       rxerr_f;
    logic       tmo_f;
    logic       stmo_f;
    logic       nack_f;
    logic [7:0] dbuf;
    logic       ctrl_wr;
    logic       stat_wr;
    logic       data_wr;
    logic       data_rd;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);
    assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
    assign data_rd = reg_rd && (reg_addr == ADDR_DATA);

    assign tx_start = data_wr && en && dir_q && tx_idle && !rx_busy;
    assign tx_byte  = reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= 1'b0;
            dir_q   <= 1'b0;
            rdy     <= 1'b0;
            rxerr_f <= 1'b0;
            tmo_f   <= 1'b0;
            stmo_f  <= 1'b0;
            nack_f  <= 1'b0;
            dbuf    <= '0;
        end else begin
            if (ctrl_wr) begin
                en    <= reg_wdata[0];
                dir_q <= reg_wdata[1];
            end else if (evt.tx_end) begin
                dir_q <= 1'b0;
            end
            if (evt.rx_done) begin
                rdy  <= 1'b1;
                dbuf <= rx_byte;
            end else if (data_rd) begin
                rdy <= 1'b0;
            end
            rxerr_f <= evt.rx_err    | (rxerr_f & ~(stat_wr & reg_wdata[ST_RXERR]));
            tmo_f   <= evt.tx_tmo    | (tmo_f   & ~(stat_wr & reg_wdata[ST_TMO]));
            stmo_f  <= evt.tx_st_tmo | (stmo_f  & ~(stat_wr & reg_wdata[ST_STMO]));
            nack_f  <= evt.tx_nack   | (nack_f  & ~(stat_wr & reg_wdata[ST_NACK]));
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {6'b0, dir_q, en};
            ADDR_STAT: reg_rdata = {1'b0, nack_f, stmo_f, tmo_f, rxerr_f, tx_idle, rx_busy, rdy};
            ADDR_DATA: reg_rdata = dbuf;
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign irq = rdy | tmo_f | stmo_f;

    // R2
    rdy_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(evt.rx_done));

    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !evt.rx_done) |=> !rdy);

    // R8
    dir_revert_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.tx_end && !ctrl_wr) |=> !dir_q);

    // R12
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (tmo_f && !(stat_wr && reg_wdata[ST_TMO])) |=> tmo_f);

endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
    import ps2hp_pkg::*;
#(
    parameter int RTS_CYCLES = 2000,
    parameter int START_TMO  = 10000,
    parameter int FRAME_TMO  = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic       ps2_clk_low,
    output logic       ps2_dat_low,
    output logic       irq
);
    logic [1:0] line_s;
    eng_evt_t   evt;
    logic [7:0] rx_byte;
    logic [7:0] tx_byte;
    logic       rx_busy;
    logic       tx_idle;
    logic       en;
    logic       tx_start;

    ps2hp_sync #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ps2_dat_in, ps2_clk_in}),
        .q   (line_s)
    );

    ps2hp_engine #(
        .RTS_CYCLES (RTS_CYCLES),
        .START_TMO  (START_TMO),
        .FRAME_TMO  (FRAME_TMO)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tx_start (tx_start),
        .tx_byte  (tx_byte),
        .clk_s    (line_s[0]),
        .dat_s    (line_s[1]),
        .evt      (evt),
        .rx_byte  (rx_byte),
        .rx_busy  (rx_busy),
        .tx_idle  (tx_idle),
        .clk_low  (ps2_clk_low),
        .dat_low  (ps2_dat_low)
    );

    ps2hp_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt       (evt),
        .rx_byte   (rx_byte),
        .rx_busy   (rx_busy),
        .tx_idle   (tx_idle),
        .en        (en),
        .tx_start  (tx_start),
        .tx_byte   (tx_byte),
        .irq       (irq)
    );
endmodule

// File: tb/tb_ps2_host_port.sv
module tb_ps2_host_port;
    localparam int RTS  = 16;
    localparam int STO  = 200;
    localparam int FTO  = 600;
    localparam int HALF = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ps2_clk_low;
    logic       ps2_dat_low;
    logic       irq;
    logic       dev_clk = 1'b1;
    logic       dev_dat = 1'b1;
    logic       clk_line;
    logic       dat_line;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [10:0] seen;
    int rts_len;

    assign clk_line = dev_clk & ~ps2_clk_low;
    assign dat_line = dev_dat & ~ps2_dat_low;

    always #2 clk = ~clk;

    ps2_host_port #(.RTS_CYCLES(RTS), .START_TMO(STO), .FRAME_TMO(FTO)) dut (
        .clk (clk), .rst (rst),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .ps2_clk_in (clk_line), .ps2_dat_in (dat_line),
        .ps2_clk_low (ps2_clk_low), .ps2_dat_low (ps2_dat_low),
        .irq (irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        tick(1);
        reg_rd = 1'b0;
    endtask

    task automatic pulse();
        tick(HALF); dev_clk = 1'b0;
        tick(HALF); dev_clk = 1'b1;
    endtask

    task automatic dev_send(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        logic [10:0] fr;
        fr = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            dev_dat = fr[i];
            pulse();
        end
        dev_dat = 1'b1;
        tick(HALF);
    endtask

    task automatic dev_take(input int pulses, input bit ack_low);
        int guard;
        guard = 0;
        seen = '0;
        rts_len = 0;
        while (!ps2_clk_low && guard < 100) begin tick(1); guard++; end
        while (ps2_clk_low && rts_len < 1000) begin rts_len++; tick(1); end
        for (int i = 0; i < pulses; i++) begin
            if (i < 11) seen[i] = dat_line;
            pulse();
        end
        if (pulses == 11) begin
            dev_dat = ack_low ? 1'b0 : 1'b1;
            pulse();
            dev_dat = 1'b1;
            tick(4);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] b;
        tick(5);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        reg_read(2'd0, r); check("R1 ctrl after reset", r, 0);
        reg_read(2'd1, r); check("R1 status after reset", r, 8'h04);
        check("R1 clock held low", ps2_clk_low, 1);
        check("R1 irq after reset", irq, 0);

        // R1 inhibited: device frame is blocked
        dev_send(8'hA5, 0, 0);
        reg_read(2'd1, r); check("R1 no byte while inhibited", r[0], 0);

        reg_write(2'd0, 8'h01);
        tick(4);
        check("R1 clock released when enabled", ps2_clk_low, 0);

        // R2 R3 exhaustive receive sweep
        for (int v = 0; v < 256; v++) begin
            dev_send(8'(v), 0, 0);
            reg_read(2'd1, r); check("R2 ready set", r[0], 1);
            check("R2 irq raised", irq, 1);
            reg_read(2'd2, r); check("R2 received byte", r, v);
            reg_read(2'd1, r); check("R3 ready cleared by read", r[0], 0);
            check("R3 irq dropped", irq, 0);
        end

        // R4 bad parity and bad stop
        dev_send(8'h3C, 1, 0);
        reg_read(2'd1, r);
        check("R4 parity error flag", r[3], 1);
        check("R4 no ready on parity error", r[0], 0);
        reg_write(2'd1, 8'h08);
        reg_read(2'd1, r); check("R4 error cleared by W1C", r[3], 0);
        dev_send(8'h3C, 0, 1);
        reg_read(2'd1, r);
        check("R4 stop error flag", r[3], 1);
        check("R4 no ready on stop error", r[0], 0);
        reg_write(2'd1, 8'h08);

        // R6 data write in receive mode ignored
        reg_write(2'd2, 8'h77);
        tick(RTS + 20);
        check("R6 no request in receive mode", ps2_clk_low, 0);
        reg_read(2'd1, r); check("R6 tx idle stays", r[2], 1);

        // R5 data write during a receive frame ignored
        reg_write(2'd0, 8'h03);
        fork
            dev_send(8'hC3, 0, 0);
            begin
                tick(HALF * 6);
                reg_read(2'd1, r); check("R5 receive busy mid frame", r[1], 1);
                reg_write(2'd2, 8'h11);
            end
        join
        check("R5 no request after blocked write", ps2_clk_low, 0);
        tick(RTS + 10);
        check("R5 still no request", ps2_clk_low, 0);
        reg_read(2'd1, r);
        check("R5 frame still received", r[0], 1);
        check("R5 tx idle", r[2], 1);
        reg_read(2'd2, r); check("R5 byte intact", r, 8'hC3);

        // R7 R8 transmit sweep
        for (int k = 0; k < 16; k++) begin
            b = 8'(k * 37 + 5);
            reg_write(2'd0, 8'h03);
            reg_write(2'd2, b);
            dev_take(11, 1);
            check("R7 request length", rts_len, RTS);
            check("R7 frame on wire", seen, {1'b1, ~^b, b, 1'b0});
            reg_read(2'd0, r); check("R8 direction reverted", r, 1);
            reg_read(2'd1, r);
            check("R8 tx idle after transmit", r[2], 1);
            check("R8 acknowledge accepted", r[6], 0);
        end

        // R9 missing acknowledge
        reg_write(2'd0, 8'h03);
        reg_write(2'd2, 8'h96);
        dev_take(11, 0);
        reg_read(2'd1, r); check("R9 no-ack flag", r[6], 1);
        check("R9 no irq for no-ack", irq, 0);
        reg_write(2'd1, 8'h40);
        reg_read(2'd1, r); check("R9 no-ack cleared", r[6], 0);

        // R10 start timeout
        reg_write(2'd0, 8'h03);
        reg_write(2'd2, 8'h5A);
        tick(RTS + STO + 10);
        reg_read(2'd1, r); check("R10 start timeout flag", r[5], 1);
        check("R10 irq on start timeout", irq, 1);
        check("R10 clock released", ps2_clk_low, 0);
        check("R10 data released", ps2_dat_low, 0);
        reg_read(2'd0, r); check("R10 direction reverted", r, 1);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, r); check("R12 zero write keeps start flag", r[5], 1);
        reg_write(2'd1, 8'h20);
        reg_read(2'd1, r); check("R12 start flag cleared", r[5], 0);
        check("R12 irq dropped", irq, 0);

        // R11 frame timeout
        reg_write(2'd0, 8'h03);
        reg_write(2'd2, 8'hE1);
        dev_take(3, 0);
        tick(FTO + 50);
        reg_read(2'd1, r); check("R11 frame timeout flag", r[4], 1);
        check("R11 irq on frame timeout", irq, 1);
        reg_read(2'd0, r); check("R11 direction reverted", r, 1);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, r); check("R12 zero write keeps frame flag", r[4], 1);
        reg_write(2'd1, 8'h10);
        reg_read(2'd1, r); check("R12 frame flag cleared", r[4], 0);
        check("R12 irq low after clear", irq, 0);

        // R1 inhibit again
        reg_write(2'd0, 8'h00);
        tick(2);
        check("R1 clock held low on disable", ps2_clk_low, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule